// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

The block is one copy channel that moves data between two descriptor rings held in a shared word-wide memory. Software fills the source ring with descriptors that point at filled buffers. It fills the destination ring with descriptors that point at empty receive buffers. It then publishes each ring by writing that ring's write index. The engine walks the source ring from its read index and copies the words of each source buffer into the current destination buffer. When the transfer is complete it writes the total byte count into the destination descriptor. A nonzero count there tells software that the buffer holds data.

Every descriptor is two 32-bit words at ring base + 8 x index. The first word is the buffer byte address. The second word holds the byte count in bits 15:0 and flags in bits 31:16. Bit 16 is gather, bit 17 is swap, and bits 31:20 carry a transfer id that the engine ignores. A source descriptor with gather set is combined with the descriptors after it into a single destination buffer and a single completion. Software talks to the engine through a small word-indexed register port with combinational read-back. Memory is a synchronous single port: read data appears on the cycle after the request.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset, both read indices and both ring sizes read 0, the maximum length reads 0xFFFF, and no memory request is made.
- R2: Ring sizes are powers of two. Every index is compared and advanced modulo the size, so a raw write index of 4 on a 4-entry ring means slot 0. The current read indices can be read at register 3 (source) and register 7 (destination). Register map: 0 source base, 1 source size, 2 source write index, 4 destination base, 5 destination size, 6 destination write index, 8 maximum length, 9 swap enables (bit 0 source ring, bit 1 destination ring).
- R3: The engine consumes a source descriptor only while the source read index differs from the published write index. When the two are equal it makes no memory request.
- R4: For each transfer the engine copies ceil(n/4) whole words from the source buffer to the destination buffer and touches no word beyond them. After the last data write it writes {16'h0, total bytes} into the second word of the destination descriptor. It then advances the destination read index.
- R5: If no destination buffer is published (destination read index equals its write index), the engine waits without consuming the source descriptor. It resumes once the destination write index advances.
- R6: Source descriptors with gather set are appended to the same destination buffer, each advancing the source read index. The first descriptor without gather completes the buffer with one count write-back holding the sum of the lengths. The count stays 0 while the list is only partly published. Every gather descriptor except the last is assumed to carry a multiple of 4 bytes.
- R7: The bytes taken from one source descriptor are the smaller of its byte count and the maximum length register.
- R8: The source-ring enable, the destination-ring enable and the descriptor swap flag each reverse the byte order of every copied word, so an even number of them cancels.
- R9: A ring with size 0 is disabled, and the engine then makes no memory request.
- R10: Writing a ring's size register clears that ring's read index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The hardest state to reach from the ports is a gather list that is only partly published. In that state the engine has consumed the first fragments and holds a destination buffer, but no completion may appear. The bench places three linked descriptors in memory and publishes the source write index in two steps. Between the steps it confirms that the source read index has moved, that the destination read index has not, and that the count word is still zero. A second staged case publishes a source descriptor with no receive buffer behind it and checks that the engine issues no memory traffic until the destination index is published. A sweep over every combination of the three swap controls and many byte counts, wrapping both rings several times, covers the copy path.

// File: rtl/ring_copy_engine.sv
`timescale 1ns/1ps
module ring_copy_engine #(
  parameter int AW = 12,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int LW = 16;
  localparam int CW = LW - 1;

  typedef enum logic [2:0] {S_IDLE, S_SD1, S_SD2, S_DD, S_RD, S_WR, S_FIN, S_WB} st_t;

  logic [31:0]   src_base, dst_base;
  logic [IW-1:0] src_size, dst_size, src_wr, dst_wr, src_rd, dst_rd;
  logic [LW-1:0] max_len;
  logic          swap_src, swap_dst;

  st_t           st;
  logic [AW-1:0] buf_w, dbuf_w, dcnt;
  logic [LW-1:0] take, total;
  logic [CW-1:0] wcnt, nw;
  logic          g_flag, s_flag, have_dst;

  wire src_sz_we = reg_we && reg_addr == 4'd1;
  wire dst_sz_we = reg_we && reg_addr == 4'd5;

  wire [IW-1:0] smask = src_size - 1'b1;
  wire [IW-1:0] dmask = dst_size - 1'b1;
  wire src_pend = src_size != '0 && src_rd != (src_wr & smask);
  wire dst_pend = dst_size != '0 && dst_rd != (dst_wr & dmask);
  wire go = src_pend && dst_pend;

  wire [AW-1:0] src_dw = src_base[AW+1:2] + AW'({src_rd, 1'b0});
  wire [AW-1:0] dst_dw = dst_base[AW+1:2] + AW'({dst_rd, 1'b0});

  assign nw = {1'b0, take[LW-1:2]} + CW'(take[1:0] != 2'b00);

  wire do_swap = s_flag ^ swap_src ^ swap_dst;
  wire [31:0] cp_data = do_swap ? {mem_rdata[7:0], mem_rdata[15:8], mem_rdata[23:16], mem_rdata[31:24]}
                                : mem_rdata;
  wire [LW-1:0] len_in = mem_rdata[LW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_base <= '0; dst_base <= '0;
      src_size <= '0; dst_size <= '0;
      src_wr   <= '0; dst_wr   <= '0;
      max_len  <= '1;
      swap_src <= 1'b0; swap_dst <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        4'd0: src_base <= reg_wdata;
        4'd1: src_size <= reg_wdata[IW-1:0];
        4'd2: src_wr   <= reg_wdata[IW-1:0];
        4'd4: dst_base <= reg_wdata;
        4'd5: dst_size <= reg_wdata[IW-1:0];
        4'd6: dst_wr   <= reg_wdata[IW-1:0];
        4'd8: max_len  <= reg_wdata[LW-1:0];
        4'd9: begin swap_src <= reg_wdata[0]; swap_dst <= reg_wdata[1]; end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = src_base;
      4'd1: reg_rdata = 32'(src_size);
      4'd2: reg_rdata = 32'(src_wr);
      4'd3: reg_rdata = 32'(src_rd);
      4'd4: reg_rdata = dst_base;
      4'd5: reg_rdata = 32'(dst_size);
      4'd6: reg_rdata = 32'(dst_wr);
      4'd7: reg_rdata = 32'(dst_rd);
      4'd8: reg_rdata = 32'(max_len);
      4'd9: reg_rdata = {30'b0, swap_dst, swap_src};
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    case (st)
      S_IDLE: if (go) begin mem_req = 1'b1; mem_addr = src_dw; end
      S_SD1:  begin mem_req = 1'b1; mem_addr = src_dw + AW'(1); end
      S_SD2:  if (!have_dst) begin mem_req = 1'b1; mem_addr = dst_dw; end
      S_RD:   if (wcnt != nw) begin mem_req = 1'b1; mem_addr = buf_w + AW'(wcnt); end
      S_WR:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dbuf_w + dcnt; mem_wdata = cp_data; end
      S_WB:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst_dw + AW'(1); mem_wdata = {16'h0, total}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_rd <= '0; dst_rd <= '0;
      buf_w <= '0; dbuf_w <= '0; dcnt <= '0;
      take <= '0; total <= '0; wcnt <= '0;
      g_flag <= 1'b0; s_flag <= 1'b0; have_dst <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) st <= S_SD1;
        S_SD1: begin
          buf_w <= mem_rdata[AW+1:2];
          st <= S_SD2;
        end
        S_SD2: begin
          g_flag <= mem_rdata[16];
          s_flag <= mem_rdata[17];
          take   <= (len_in > max_len) ? max_len : len_in;
          wcnt   <= '0;
          st     <= have_dst ? S_RD : S_DD;
        end
        S_DD: begin
          dbuf_w   <= mem_rdata[AW+1:2];
          dcnt     <= '0;
          have_dst <= 1'b1;
          st       <= S_RD;
        end
        S_RD: st <= (wcnt == nw) ? S_FIN : S_WR;
        S_WR: begin
          wcnt <= wcnt + 1'b1;
          dcnt <= dcnt + 1'b1;
          st   <= S_RD;
        end
        S_FIN: begin
          src_rd <= (src_rd + 1'b1) & smask;
          total  <= total + take;
          st     <= g_flag ? S_IDLE : S_WB;
        end
        S_WB: begin
          dst_rd   <= (dst_rd + 1'b1) & dmask;
          total    <= '0;
          have_dst <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (src_sz_we) src_rd <= '0;
      if (dst_sz_we) dst_rd <= '0;
    end
  end

  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd != $past(src_rd)) && !$past(src_sz_we) |-> $past(src_rd != (src_wr & smask)));

  a_r2_src_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd != $past(src_rd)) && !$past(src_sz_we) |-> src_rd == (($past(src_rd) + 1'b1) & $past(smask)));

  a_r5_dst_posted: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st == S_WB) |-> dst_rd != (dst_wr & dmask));

  a_r7_word_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |-> wcnt < nw);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_size == '0 && $past(src_size) == '0 && $past(st) == S_IDLE) |-> st == S_IDLE);
endmodule

// File: tb/tb_ring_copy_engine.sv
`timescale 1ns/1ps
module tb_ring_copy_engine;
  localparam int AW = 12;
  localparam int SRC_RING = 'h000;
  localparam int DST_RING = 'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [0:(1<<AW)-1];

  int nchk = 0, nfail = 0, req_cnt = 0;
  int sidx = 0, didx = 0;

  always #2 clk = ~clk;

  ring_copy_engine #(.AW(AW), .IW(16)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
    if (rst_n && mem_req) req_cnt <= req_cnt + 1;
  end

  function automatic logic [31:0] pat(int t, int k);
    return {8'(t), 8'(k), 8'h5A, 8'(t * 3 + k)};
  endfunction

  function automatic logic [31:0] bsw(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idx(int s_exp, int d_exp);
    logic [31:0] a, b;
    for (int i = 0; i < 2000; i++) begin
      rreg(4'd3, a); rreg(4'd7, b);
      if (a == 32'(s_exp) && b == 32'(d_exp)) break;
    end
  endtask

  task automatic post_src(int slot, int bufa, int len, bit g, bit sw);
    mem[(SRC_RING + slot * 8) >> 2]     = 32'(bufa);
    mem[((SRC_RING + slot * 8) >> 2) + 1] = {14'h0, sw, g, 16'(len)};
  endtask

  task automatic post_dst(int slot, int bufa);
    mem[(DST_RING + slot * 8) >> 2]     = 32'(bufa);
    mem[((DST_RING + slot * 8) >> 2) + 1] = 32'h0;
  endtask

  function automatic int cnt_word(int slot);
    return ((DST_RING + slot * 8) >> 2) + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0, s, d, len, sb, db, nw;
    bit se, de, df;
    logic [31:0] e [5];
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    mem_rdata = '0;
    repeat (4) @(negedge clk);
    check("R1 mem_req in reset", {31'b0, mem_req}, 32'h0);
    rst_n = 1'b1;
    rreg(4'd3, v); check("R1 src read index", v, 0);
    rreg(4'd7, v); check("R1 dst read index", v, 0);
    rreg(4'd1, v); check("R1 src size", v, 0);
    rreg(4'd8, v); check("R1 max length", v, 32'hFFFF);
    check("R1 no requests", 32'(req_cnt), 0);

    wreg(4'd0, SRC_RING); wreg(4'd1, 4);
    wreg(4'd4, DST_RING); wreg(4'd5, 4);
    wreg(4'd2, 0); wreg(4'd6, 0);

    for (int t = 0; t < 24; t++) begin
      s = sidx & 3; d = didx & 3;
      se = t[0]; de = t[1]; df = t[2];
      len = 1 + (t * 7) % 20;
      sb = 'h400 + s * 'h40; db = 'h800 + d * 'h40;
      wreg(4'd9, {30'b0, de, se});
      for (int k = 0; k < 16; k++) begin
        mem[(sb >> 2) + k] = pat(t, k);
        mem[(db >> 2) + k] = '0;
      end
      post_src(s, sb, len, 1'b0, df);
      post_dst(d, db);
      wreg(4'd6, didx + 1);
      wreg(4'd2, sidx + 1);
      sidx++; didx++;
      wait_idx(sidx & 3, didx & 3);
      nw = (len + 3) / 4;
      for (int k = 0; k < nw; k++)
        check((se ^ de ^ df) ? "R8 swapped word" : "R4 copied word",
              mem[(db >> 2) + k], (se ^ de ^ df) ? bsw(pat(t, k)) : pat(t, k));
      check("R4 word past end untouched", mem[(db >> 2) + nw], 0);
      check("R4 count write-back", mem[cnt_word(d)], 32'(len));
      rreg(4'd3, v); check("R2 src read index wrap", v, 32'(sidx & 3));
      rreg(4'd7, v); check("R2 dst read index wrap", v, 32'(didx & 3));
    end

    c0 = req_cnt;
    repeat (30) @(negedge clk);
    check("R3 idle when indices equal", 32'(req_cnt), 32'(c0));

    wreg(4'd9, 0);
    wreg(4'd8, 6);
    s = sidx & 3; d = didx & 3;
    sb = 'h400 + s * 'h40; db = 'h800 + d * 'h40;
    for (int k = 0; k < 16; k++) begin
      mem[(sb >> 2) + k] = pat(50, k);
      mem[(db >> 2) + k] = '0;
    end
    post_src(s, sb, 20, 1'b0, 1'b0); post_dst(d, db);
    wreg(4'd6, didx + 1); wreg(4'd2, sidx + 1);
    sidx++; didx++;
    wait_idx(sidx & 3, didx & 3);
    check("R7 word 0", mem[(db >> 2)], pat(50, 0));
    check("R7 word 1", mem[(db >> 2) + 1], pat(50, 1));
    check("R7 word 2 not copied", mem[(db >> 2) + 2], 0);
    check("R7 clamped count", mem[cnt_word(d)], 6);
    wreg(4'd8, 32'hFFFF);

    s = sidx & 3; d = didx & 3;
    sb = 'h400 + s * 'h40; db = 'h800 + d * 'h40;
    for (int k = 0; k < 16; k++) begin
      mem[(sb >> 2) + k] = pat(60, k);
      mem[(db >> 2) + k] = '0;
    end
    post_src(s, sb, 8, 1'b0, 1'b0); post_dst(d, db);
    wreg(4'd2, sidx + 1);
    c0 = req_cnt;
    repeat (40) @(negedge clk);
    check("R5 no traffic without buffer", 32'(req_cnt), 32'(c0));
    rreg(4'd3, v); check("R5 source not consumed", v, 32'(sidx & 3));
    check("R5 count still zero", mem[cnt_word(d)], 0);
    wreg(4'd6, didx + 1);
    sidx++; didx++;
    wait_idx(sidx & 3, didx & 3);
    check("R5 resumed word 0", mem[(db >> 2)], pat(60, 0));
    check("R5 resumed word 1", mem[(db >> 2) + 1], pat(60, 1));
    check("R5 resumed count", mem[cnt_word(d)], 8);

    d = didx & 3; db = 'h800 + d * 'h40;
    for (int k = 0; k < 16; k++) mem[(db >> 2) + k] = '0;
    for (int i = 0; i < 3; i++) begin
      s = (sidx + i) & 3; sb = 'h400 + s * 'h40;
      for (int k = 0; k < 16; k++) mem[(sb >> 2) + k] = pat(100 + i, k);
      post_src(s, sb, (i == 0) ? 8 : (i == 1) ? 4 : 6, i != 2, 1'b0);
    end
    post_dst(d, db);
    wreg(4'd6, didx + 1);
    wreg(4'd2, sidx + 2);
    wait_idx((sidx + 2) & 3, didx & 3);
    repeat (20) @(negedge clk);
    rreg(4'd3, v); check("R6 partial list consumed", v, 32'((sidx + 2) & 3));
    rreg(4'd7, v); check("R6 no completion yet", v, 32'(didx & 3));
    check("R6 count zero while partial", mem[cnt_word(d)], 0);
    wreg(4'd2, sidx + 3);
    sidx += 3; didx++;
    wait_idx(sidx & 3, didx & 3);
    e[0] = pat(100, 0); e[1] = pat(100, 1); e[2] = pat(101, 0);
    e[3] = pat(102, 0); e[4] = pat(102, 1);
    for (int k = 0; k < 5; k++) check("R6 merged word", mem[(db >> 2) + k], e[k]);
    check("R6 merged word past end", mem[(db >> 2) + 5], 0);
    check("R6 single merged count", mem[cnt_word(d)], 18);
    rreg(4'd7, v); check("R6 one destination consumed", v, 32'(didx & 3));

    wreg(4'd1, 0);
    rreg(4'd3, v); check("R10 size write clears read index", v, 0);
    d = didx & 3;
    post_dst(d, 'h800 + d * 'h40);
    wreg(4'd6, didx + 1);
    wreg(4'd2, sidx + 1);
    c0 = req_cnt;
    repeat (40) @(negedge clk);
    check("R9 disabled ring makes no request", 32'(req_cnt), 32'(c0));
    rreg(4'd7, v); check("R9 destination untouched", v, 32'(didx & 3));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule